// File: doc/BRIEF.md
# UDP Heartbeat Frame Generator

This block produces a periodic heartbeat frame for a gigabit Ethernet transmit path. On a fixed period it emits one complete Ethernet II frame carrying an IPv4/UDP datagram as a stream of bytes, one byte per clock, with a data-valid flag. The stream feeds a double-data-rate output stage, which is outside this block. Every frame starts with the preamble and start delimiter. The hardware and protocol addresses are elaboration parameters. The IPv4 header checksum is computed in hardware, and a CRC-32 frame check sequence is appended. The IPv4 identification field counts frames, so each frame differs from the previous one and its header checksum changes with it.

The controller is a single state machine with six states:
- `S_IDLE` counts the inter-frame gap. Transition *gap_done* leads to `S_PRE`.
- `S_PRE` sends the seven preamble bytes. Transition *pre_last* leads to `S_SFD`.
- `S_SFD` sends the start delimiter. The transition to `S_HDR` is unconditional, and the CRC is re-seeded here.
- `S_HDR` sends 42 header bytes for the MAC, IPv4 and UDP headers. Transition *hdr_last* leads to `S_PAY`.
- `S_PAY` sends the payload bytes. Transition *pay_last* leads to `S_FCS`.
- `S_FCS` sends the four check bytes. Transition *fcs_last* returns to `S_IDLE` and advances the identification counter.

The output byte and flag are registered, so the ports follow the state by one clock.

Top module: `hb_frame_gen`

## Requirements
- R1: While reset is asserted and for the first gap period after it is released, tx_en is 0 and tx_dat is 0x00.
- R2: Each frame begins with seven bytes of 0x55 and then one byte of 0xD5.
- R3: After the delimiter come exactly 14+20+8+PAYLOAD_LEN+4 bytes (106 by default). The first 14 of these are the destination MAC, then the source MAC, then the type 0x0800. All multi-byte fields are sent most significant byte first.
- R4: The IPv4 header bytes are, in order:
  - 0x45, 0x00;
  - total length 28+PAYLOAD_LEN;
  - identification, which is 0 in the first frame after reset and then increments by one per frame;
  - 0x40, 0x00;
  - TTL 0x40, protocol 0x11;
  - the checksum;
  - the source IP, then the destination IP.
- R5: The IPv4 checksum (header bytes 10-11) is the ones'-complement of the ones'-complement sum of the ten header words, with the checksum word taken as zero. A receiver's sum over all ten words is therefore 0xFFFF.
- R6: The UDP header carries, in order, the source port, the destination port, the length 8+PAYLOAD_LEN and a checksum of 0x0000.
- R7: Payload byte j equals (PAY_BASE + j) mod 256.
- R8: The last four bytes are the complement of a CRC-32 (polynomial 0x04C11DB7, all-ones seed, each byte fed least significant bit first) taken over every byte from the destination MAC through the payload. The CRC register is sent in bit-reflected form, low-order byte first.
- R9: tx_en is 1 without a break from the first preamble byte through the last check byte. Between frames tx_en is 0 and tx_dat is 0x00.
- R10: Frames start every FRAME_PERIOD clocks, so the idle gap is FRAME_PERIOD-(8+106). When FRAME_PERIOD is too short, the gap is held at 12 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_dat | output | 8 | Frame byte, single-edge |
| tx_en | output | 1 | High while tx_dat carries a frame byte |

## Verification
A wrong state or a wrong byte index shows at the ports within one clock:
- a misplaced delimiter, or a header field shifted by one byte;
- a gap of the wrong length, seen at the next rising edge of tx_en.

A corrupt identification counter or checksum shows up within the current frame's header bytes. A CRC fault stays hidden until the last four bytes of the frame.

The bench compares every output byte against a behavioural frame model on every clock. It also checks each captured frame the way a receiver would: it re-sums the IPv4 header and recomputes the CRC over the received bytes. A second instance with a short period exercises the minimum-gap clamp.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int PRE_LEN = 7;
    localparam int HDR_LEN = 42;
    localparam int FCS_LEN = 4;
    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_PRE  = 3'd1,
        S_SFD  = 3'd2,
        S_HDR  = 3'd3,
        S_PAY  = 3'd4,
        S_FCS  = 3'd5
    } hb_state_e;

    // Reflected CRC-32 step over one byte, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c_in,
                                               input logic [7:0]  d);
        logic [31:0] c;
        c = c_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ d[b]) c = (c >> 1) ^ 32'hEDB8_8320;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/hb_gap_timer.sv
module hb_gap_timer #(
    parameter int GAP = 46
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(GAP + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!run || cnt == LAST) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    a_r10_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    a_r10_gap_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/hb_ip_csum.sv
module hb_ip_csum #(
    parameter logic [31:0] SRC_IP = 32'hC0A8_010A,
    parameter logic [31:0] DST_IP = 32'hC0A8_0102,
    parameter int          PAYLOAD_LEN = 60
) (
    input  logic [15:0] ident,
    output logic [15:0] csum
);
    localparam logic [15:0] IP_LEN = 16'(20 + 8 + PAYLOAD_LEN);
    localparam logic [19:0] FIXED_SUM =
        20'h4500 + 20'(IP_LEN) + 20'h4000 + 20'h4011 +
        20'(SRC_IP[31:16]) + 20'(SRC_IP[15:0]) +
        20'(DST_IP[31:16]) + 20'(DST_IP[15:0]);

    logic [19:0] raw;
    logic [16:0] fold1;
    logic [16:0] fold2;

    always_comb begin
        raw   = FIXED_SUM + 20'(ident);
        fold1 = 17'(raw[15:0]) + 17'(raw[19:16]);
        fold2 = 17'(fold1[15:0]) + 17'(fold1[16]);
        csum  = ~fold2[15:0];
    end

    // Receiver view: all ten words including the checksum must sum to 0xFFFF.
    logic [19:0] rx_raw;
    logic [16:0] rx_f1;
    logic [16:0] rx_f2;
    always_comb begin
        rx_raw = FIXED_SUM + 20'(ident) + 20'(csum);
        rx_f1  = 17'(rx_raw[15:0]) + 17'(rx_raw[19:16]);
        rx_f2  = 17'(rx_f1[15:0]) + 17'(rx_f1[16]);
        if (!$isunknown(ident))
            a_r5_csum_verifies: assert (rx_f2[15:0] == 16'hFFFF);
    end
endmodule

// File: rtl/hb_hdr_mux.sv
module hb_hdr_mux #(
    parameter logic [47:0] DST_MAC  = 48'h021A_2B3C_4D5E,
    parameter logic [47:0] SRC_MAC  = 48'h0211_2233_4455,
    parameter logic [31:0] SRC_IP   = 32'hC0A8_010A,
    parameter logic [31:0] DST_IP   = 32'hC0A8_0102,
    parameter logic [15:0] SRC_PORT = 16'h1F90,
    parameter logic [15:0] DST_PORT = 16'h1F91,
    parameter int          PAYLOAD_LEN = 60
) (
    input  logic [5:0]  sel,
    input  logic [15:0] ident,
    input  logic [15:0] csum,
    output logic [7:0]  dout
);
    import hb_pkg::*;

    localparam logic [15:0] IP_LEN  = 16'(20 + 8 + PAYLOAD_LEN);
    localparam logic [15:0] UDP_LEN = 16'(8 + PAYLOAD_LEN);

    logic [HDR_LEN*8-1:0] hdr;
    logic [7:0]           hb [HDR_LEN];

    assign hdr = {DST_MAC, SRC_MAC, 16'h0800,
                  8'h45, 8'h00, IP_LEN, ident, 16'h4000,
                  8'h40, 8'h11, csum, SRC_IP, DST_IP,
                  SRC_PORT, DST_PORT, UDP_LEN, 16'h0000};

    for (genvar g = 0; g < HDR_LEN; g++) begin : g_byte
        assign hb[g] = hdr[(HDR_LEN-1-g)*8 +: 8];
    end

    always_comb begin
        dout = 8'h00;
        for (int i = 0; i < HDR_LEN; i++)
            if (sel == 6'(i)) dout = hb[i];
    end
endmodule

// File: rtl/hb_crc32.sv
module hb_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    import hb_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc <= '1;
        else if (init) crc <= '1;
        else if (upd)  crc <= crc32_step(crc, din);
    end

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !upd) |=> $stable(crc));
endmodule

// File: rtl/hb_frame_gen.sv
module hb_frame_gen #(
    parameter logic [47:0] DST_MAC      = 48'h021A_2B3C_4D5E,
    parameter logic [47:0] SRC_MAC      = 48'h0211_2233_4455,
    parameter logic [31:0] SRC_IP       = 32'hC0A8_010A,
    parameter logic [31:0] DST_IP       = 32'hC0A8_0102,
    parameter logic [15:0] SRC_PORT     = 16'h1F90,
    parameter logic [15:0] DST_PORT     = 16'h1F91,
    parameter int          PAYLOAD_LEN  = 60,
    parameter logic [7:0]  PAY_BASE     = 8'h30,
    parameter int          FRAME_PERIOD = 160
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [7:0] tx_dat,
    output logic       tx_en
);
    import hb_pkg::*;

    localparam int MIN_GAP   = 12;
    localparam int FRAME_LEN = PRE_LEN + 1 + HDR_LEN + PAYLOAD_LEN + FCS_LEN;
    localparam int GAP       = (FRAME_PERIOD >= FRAME_LEN + MIN_GAP) ?
                               FRAME_PERIOD - FRAME_LEN : MIN_GAP;
    localparam int IDX_MAX   = (PAYLOAD_LEN > HDR_LEN) ? PAYLOAD_LEN : HDR_LEN;
    localparam int IDX_W     = $clog2(IDX_MAX + 1);

    localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PRE_LEN - 1);
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_LEN - 1);
    localparam logic [IDX_W-1:0] PAY_LAST = IDX_W'(PAYLOAD_LEN - 1);
    localparam logic [IDX_W-1:0] FCS_LAST = IDX_W'(FCS_LEN - 1);

    hb_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [15:0]      ident;
    logic             gap_done;
    logic [15:0]      csum;
    logic [7:0]       hdr_byte;
    logic [31:0]      crc;
    logic [7:0]       dat_nxt;
    logic             en_nxt;
    logic             crc_init;
    logic             crc_upd;
    logic [7:0]       pay_byte;

    hb_gap_timer #(.GAP(GAP)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == S_IDLE),
        .done  (gap_done)
    );

    hb_ip_csum #(
        .SRC_IP(SRC_IP), .DST_IP(DST_IP), .PAYLOAD_LEN(PAYLOAD_LEN)
    ) u_csum (
        .ident (ident),
        .csum  (csum)
    );

    hb_hdr_mux #(
        .DST_MAC(DST_MAC), .SRC_MAC(SRC_MAC), .SRC_IP(SRC_IP), .DST_IP(DST_IP),
        .SRC_PORT(SRC_PORT), .DST_PORT(DST_PORT), .PAYLOAD_LEN(PAYLOAD_LEN)
    ) u_hdr (
        .sel   (idx[5:0]),
        .ident (ident),
        .csum  (csum),
        .dout  (hdr_byte)
    );

    hb_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .upd   (crc_upd),
        .din   (dat_nxt),
        .crc   (crc)
    );

    // State register, byte index and frame identification.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
            ident <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    idx <= '0;
                    if (gap_done) state <= S_PRE;
                end
                S_PRE: begin
                    if (idx == PRE_LAST) begin
                        state <= S_SFD;
                        idx   <= '0;
                    end else idx <= idx + 1'b1;
                end
                S_SFD: begin
                    state <= S_HDR;
                    idx   <= '0;
                end
                S_HDR: begin
                    if (idx == HDR_LAST) begin
                        state <= S_PAY;
                        idx   <= '0;
                    end else idx <= idx + 1'b1;
                end
                S_PAY: begin
                    if (idx == PAY_LAST) begin
                        state <= S_FCS;
                        idx   <= '0;
                    end else idx <= idx + 1'b1;
                end
                S_FCS: begin
                    if (idx == FCS_LAST) begin
                        state <= S_IDLE;
                        idx   <= '0;
                        ident <= ident + 16'd1;
                    end else idx <= idx + 1'b1;
                end
                default: begin
                    state <= S_IDLE;
                    idx   <= '0;
                end
            endcase
        end
    end

    assign pay_byte = PAY_BASE + 8'(idx);

    // Byte selection for the current state.
    always_comb begin
        dat_nxt  = 8'h00;
        en_nxt   = 1'b1;
        crc_init = 1'b0;
        crc_upd  = 1'b0;
        unique case (state)
            S_IDLE: en_nxt = 1'b0;
            S_PRE:  dat_nxt = PRE_BYTE;
            S_SFD: begin
                dat_nxt  = SFD_BYTE;
                crc_init = 1'b1;
            end
            S_HDR: begin
                dat_nxt = hdr_byte;
                crc_upd = 1'b1;
            end
            S_PAY: begin
                dat_nxt = pay_byte;
                crc_upd = 1'b1;
            end
            S_FCS: dat_nxt = ~crc[8*idx[1:0] +: 8];
            default: en_nxt = 1'b0;
        endcase
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en  <= 1'b0;
            tx_dat <= 8'h00;
        end else begin
            tx_en  <= en_nxt;
            tx_dat <= dat_nxt;
        end
    end

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == S_IDLE) |-> (!tx_en && tx_dat == 8'h00));
    a_r2_sfd_before_header: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HDR && idx == '0) |-> (tx_en && tx_dat == SFD_BYTE));
    a_r4_ident_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FCS && idx == FCS_LAST) |=> ident == $past(ident) + 16'd1);
    a_r9_en_ends_after_fcs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> $past(state, 2) == S_FCS);
    a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HDR) |-> idx <= HDR_LAST);
endmodule

// File: tb/hb_frame_gen_tb.sv
module hb_frame_gen_tb;
    localparam logic [47:0] DMAC = 48'h021A_2B3C_4D5E;
    localparam logic [47:0] SMAC = 48'h0211_2233_4455;
    localparam logic [31:0] SIP  = 32'hC0A8_010A;
    localparam logic [31:0] DIP  = 32'hC0A8_0102;
    localparam logic [15:0] SP   = 16'h1F90;
    localparam logic [15:0] DP   = 16'h1F91;
    localparam int          PL   = 60;
    localparam logic [7:0]  PB   = 8'h30;
    localparam int          PER  = 160;
    localparam int          PER2 = 50;
    localparam int          FT   = 8 + 106;
    localparam int          GAP1 = PER - FT;
    localparam int          GAP2 = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] tx_dat, tx_dat2;
    logic tx_en, tx_en2;
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hb_frame_gen #(.DST_MAC(DMAC), .SRC_MAC(SMAC), .SRC_IP(SIP), .DST_IP(DIP),
        .SRC_PORT(SP), .DST_PORT(DP), .PAYLOAD_LEN(PL), .PAY_BASE(PB),
        .FRAME_PERIOD(PER)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_dat(tx_dat), .tx_en(tx_en));

    hb_frame_gen #(.DST_MAC(DMAC), .SRC_MAC(SMAC), .SRC_IP(SIP), .DST_IP(DIP),
        .SRC_PORT(SP), .DST_PORT(DP), .PAYLOAD_LEN(PL), .PAY_BASE(PB),
        .FRAME_PERIOD(PER2)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .tx_dat(tx_dat2), .tx_en(tx_en2));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // CRC in MSB-first form with reflected input bits and reflected result.
    function automatic logic [31:0] ref_fcs(input logic [7:0] b[$], input int from, input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] r;
        for (int i = from; i < from + n; i++)
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[31] ^ b[i][k];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        for (int k = 0; k < 32; k++) r[k] = c[31-k];
        return ~r;
    endfunction

    function automatic logic [15:0] fold_sum(input int s);
        while (s > 16'hFFFF) s = (s & 16'hFFFF) + (s >> 16);
        return 16'(s);
    endfunction

    logic [7:0] exp_q[$];

    task automatic push16(input logic [15:0] v);
        exp_q.push_back(v[15:8]);
        exp_q.push_back(v[7:0]);
    endtask

    task automatic build_frame(input int f);
        int s;
        logic [15:0] ck;
        exp_q.delete();
        repeat (7) exp_q.push_back(8'h55);
        exp_q.push_back(8'hD5);
        for (int i = 5; i >= 0; i--) exp_q.push_back(DMAC[i*8 +: 8]);
        for (int i = 5; i >= 0; i--) exp_q.push_back(SMAC[i*8 +: 8]);
        push16(16'h0800);
        s = 16'h4500 + (28 + PL) + (f & 16'hFFFF) + 16'h4000 + 16'h4011 +
            SIP[31:16] + SIP[15:0] + DIP[31:16] + DIP[15:0];
        ck = ~fold_sum(s);
        push16(16'h4500); push16(16'(28 + PL)); push16(16'(f));
        push16(16'h4000); push16(16'h4011); push16(ck);
        push16(SIP[31:16]); push16(SIP[15:0]); push16(DIP[31:16]); push16(DIP[15:0]);
        push16(SP); push16(DP); push16(16'(8 + PL)); push16(16'h0000);
        for (int j = 0; j < PL; j++) exp_q.push_back(8'(PB + j));
        begin
            logic [31:0] fcs;
            fcs = ref_fcs(exp_q, 8, 14 + 20 + 8 + PL);
            for (int k = 0; k < 4; k++) exp_q.push_back(fcs[k*8 +: 8]);
        end
    endtask

    function automatic string req_of(input int pos);
        if (pos < 8)            return "R2";
        if (pos < 22)           return "R3";
        if (pos == 32 || pos == 33) return "R5";
        if (pos < 42)           return "R4";
        if (pos < 50)           return "R6";
        if (pos < 50 + PL)      return "R7";
        return "R8";
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    logic [7:0] cap[$];
    int frames_seen = 0;

    task automatic check_capture();
        int s;
        logic [31:0] fcs_rx, fcs_calc;
        check(cap.size() == FT, "R3 frame length", cap.size(), FT);
        if (cap.size() != FT) return;
        for (int i = 0; i < 7; i++)
            check(cap[i] == 8'h55, "R2 preamble", cap[i], 8'h55);
        check(cap[7] == 8'hD5, "R2 delimiter", cap[7], 8'hD5);
        s = 0;
        for (int w = 0; w < 10; w++) s += {cap[22 + 2*w], cap[23 + 2*w]};
        check(fold_sum(s) == 16'hFFFF, "R5 receiver sum", fold_sum(s), 16'hFFFF);
        check({cap[26], cap[27]} == 16'(frames_seen), "R4 identification",
              {cap[26], cap[27]}, frames_seen);
        fcs_rx   = {cap[113], cap[112], cap[111], cap[110]};
        fcs_calc = ref_fcs(cap, 8, 102);
        check(fcs_rx == fcs_calc, "R8 received FCS", fcs_rx, fcs_calc);
        check({cap[48], cap[49]} == 16'h0000, "R6 UDP checksum zero",
              {cap[48], cap[49]}, 0);
        frames_seen++;
    endtask

    initial begin
        int gap_run, gap_run2;
        bit seen_end, seen_end2;
        logic prev_en;
        gap_run = 0; gap_run2 = 0; seen_end = 0; seen_end2 = 0; prev_en = 0;
        repeat (5) begin
            @(negedge clk);
            check(tx_en == 1'b0 && tx_dat == 8'h00, "R1 in reset", {tx_en, tx_dat}, 0);
        end
        rst_n = 1'b1;
        for (int n = 1; n <= 3 * PER + 60; n++) begin
            int p, pos;
            @(negedge clk);
            p = (n - 1) % PER;
            if (p < GAP1) begin
                string r;
                r = (n <= GAP1) ? "R1 first gap" : "R9 idle";
                check(tx_en == 1'b0 && tx_dat == 8'h00, r, {tx_en, tx_dat}, 0);
            end else begin
                pos = p - GAP1;
                if (pos == 0) build_frame((n - 1) / PER);
                check(tx_en == 1'b1, "R9 enable in frame", tx_en, 1);
                check(tx_dat == exp_q[pos], req_of(pos), tx_dat, exp_q[pos]);
            end
            // receiver-style capture of the first instance
            if (tx_en) cap.push_back(tx_dat);
            else if (prev_en) begin
                check_capture();
                cap.delete();
            end
            // gap measurement, R10
            if (tx_en) begin
                if (seen_end && gap_run > 0)
                    check(gap_run == GAP1, "R10 gap", gap_run, GAP1);
                gap_run = 0;
            end else begin
                if (prev_en) seen_end = 1;
                gap_run++;
            end
            if (tx_en2) begin
                if (seen_end2 && gap_run2 > 0)
                    check(gap_run2 == GAP2, "R10 minimum gap clamp", gap_run2, GAP2);
                gap_run2 = 0;
            end else begin
                gap_run2++;
                seen_end2 = seen_end2 | (gap_run2 == 1 && n > 1);
            end
            prev_en = tx_en;
        end
        check(frames_seen == 3, "R10 frame count", frames_seen, 3);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end
endmodule